// File: doc/BRIEF.md
# Planar Colour Compare Read Unit

This unit sits on the processor read path of a frame buffer that stores each pixel as four bits spread over four byte-wide planes. For every read it takes the four plane bytes fetched from the addressed location and returns one byte to the processor. Every read also copies all four plane bytes into the data latches, which a later write path can use for read-modify-write.

Two read modes are available. In direct mode the returned byte is the byte of one plane, picked by a plane-select register. In compare mode each returned bit reports whether the pixel at that bit position matches a reference colour. Only the planes enabled in a per-plane include mask take part in that match. Four control registers hold the reference colour, the include mask, the mode and the plane select. They are reached through one shared index register and a data port.

Top module: `plane_rd_unit`

## Requirements
- R1: After reset, cpu_rdata, latch_q, the index register and all control registers are zero, so reg_rdata reads 00h.
- R2: A pulse on idx_wr stores wdata as the index. A data_wr pulse writes the register named by the index held before that edge, including when idx_wr is high in the same cycle.
- R3: The include-mask register sits at index 07h and stores wdata bits 3:0. Its bits 7:4 always read back as zero.
- R4: The reference colour sits at index 02h and keeps bits 3:0. The plane select sits at 04h and keeps bits 1:0. The mode register sits at 05h and keeps only bit 3, where 1 selects compare mode. All other bits of these registers read as zero.
- R5: A write to any index not listed in R3 or R4 changes no register, and reading such an index returns 00h.
- R6: On the clock edge where fb_rd is sampled high, latch_q takes plane_data, with plane p in bits 8p+7:8p. At any other edge latch_q holds its value.
- R7: In direct mode (mode bit 3 = 0), a read returns the byte of the plane named by the plane select. The result appears on cpu_rdata after the edge where fb_rd is sampled.
- R8: In compare mode, result bit i is 1 exactly when, for every included plane p, bit i of plane p equals bit p of the reference colour.
- R9: A plane whose include-mask bit is 0 is left out of the match. With all four mask bits 0, a compare read returns FFh.
- R10: cpu_rdata changes only at an edge where fb_rd is sampled high and holds its value otherwise.
- R11: The include mask and the reference colour have no effect on direct-mode reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_wr | input | 1 | Write wdata into the index register |
| data_wr | input | 1 | Write wdata into the indexed control register |
| wdata | input | 8 | Write data for the index and control registers |
| reg_rdata | output | 8 | Read-back of the indexed control register |
| fb_rd | input | 1 | Frame-buffer read strobe |
| plane_data | input | 32 | Four fetched plane bytes, plane p in bits 8p+7:8p |
| cpu_rdata | output | 8 | Byte returned to the processor |
| latch_q | output | 32 | Data latches holding the last fetched plane bytes |

## Verification
The bench sets the include mask to zero in compare mode and expects FFh. A design that forces excluded planes to match zero, or that ANDs over an empty set wrongly, returns a data-dependent byte here. It also sets a non-zero mask and colour in direct mode, which catches a design that applies the compare path or the mask regardless of mode. Writing index and data in the same cycle exposes a data write that lands on the new index. Writes of FFh to the reserved bits, to the mode bits and to unassigned indices catch leaky readback or stray decode, and reads with changing plane data catch latches or returned data that update without a strobe.

// File: rtl/plane_rd_pkg.sv
package plane_rd_pkg;

    localparam int unsigned DEF_PLANES = 4;
    localparam int unsigned DEF_BYTE_W = 8;

    localparam logic [7:0] IDX_COLOR = 8'h02;
    localparam logic [7:0] IDX_PSEL  = 8'h04;
    localparam logic [7:0] IDX_MODE  = 8'h05;
    localparam logic [7:0] IDX_MASK  = 8'h07;

    localparam int unsigned MODE_CMP_BIT = 3;

endpackage

// File: rtl/plane_ctl_regs.sv
module plane_ctl_regs
    import plane_rd_pkg::*;
#(
    parameter int unsigned PLANES = DEF_PLANES,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    localparam int unsigned SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [PLANES-1:0] color,
    output logic [PLANES-1:0] mask,
    output logic [SEL_W-1:0]  sel,
    output logic              cmp_mode
);

    typedef struct packed {
        logic [BYTE_W-1:0] idx;
        logic [PLANES-1:0] color;
        logic [PLANES-1:0] mask;
        logic [SEL_W-1:0]  sel;
        logic              cmp_mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (data_wr) begin
            unique case (ctl_q.idx)
                BYTE_W'(IDX_COLOR): ctl_d.color    = wdata[PLANES-1:0];
                BYTE_W'(IDX_PSEL):  ctl_d.sel      = wdata[SEL_W-1:0];
                BYTE_W'(IDX_MODE):  ctl_d.cmp_mode = wdata[MODE_CMP_BIT];
                BYTE_W'(IDX_MASK):  ctl_d.mask     = wdata[PLANES-1:0];
                default: ;
            endcase
        end
        if (idx_wr) begin
            ctl_d.idx = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (ctl_q.idx)
            BYTE_W'(IDX_COLOR): reg_rdata[PLANES-1:0]  = ctl_q.color;
            BYTE_W'(IDX_PSEL):  reg_rdata[SEL_W-1:0]   = ctl_q.sel;
            BYTE_W'(IDX_MODE):  reg_rdata[MODE_CMP_BIT] = ctl_q.cmp_mode;
            BYTE_W'(IDX_MASK):  reg_rdata[PLANES-1:0]  = ctl_q.mask;
            default: ;
        endcase
    end

    assign color    = ctl_q.color;
    assign mask     = ctl_q.mask;
    assign sel      = ctl_q.sel;
    assign cmp_mode = ctl_q.cmp_mode;

endmodule

// File: rtl/plane_color_cmp.sv
module plane_color_cmp
    import plane_rd_pkg::*;
#(
    parameter int unsigned PLANES = DEF_PLANES,
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic [PLANES*BYTE_W-1:0] planes,
    input  logic [PLANES-1:0]        color,
    input  logic [PLANES-1:0]        mask,
    output logic [BYTE_W-1:0]        match
);

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic [PLANES-1:0] miss;
        for (genvar p = 0; p < PLANES; p++) begin : g_plane
            assign miss[p] = mask[p] & (planes[p*BYTE_W + b] ^ color[p]);
        end
        assign match[b] = ~|miss;
    end

endmodule

// File: rtl/plane_sel_mux.sv
module plane_sel_mux
    import plane_rd_pkg::*;
#(
    parameter int unsigned PLANES = DEF_PLANES,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    localparam int unsigned SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
    input  logic [PLANES*BYTE_W-1:0] planes,
    input  logic [SEL_W-1:0]         sel,
    output logic [BYTE_W-1:0]        byte_out
);

    logic [BYTE_W-1:0] lane [PLANES];

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        assign lane[p] = planes[p*BYTE_W +: BYTE_W];
    end

    always_comb begin
        byte_out = '0;
        for (int p = 0; p < PLANES; p++) begin
            if (SEL_W'(p) == sel) begin
                byte_out = lane[p];
            end
        end
    end

endmodule

// File: rtl/plane_rd_unit.sv
module plane_rd_unit
    import plane_rd_pkg::*;
#(
    parameter int unsigned PLANES = DEF_PLANES,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    localparam int unsigned SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1,
    localparam int unsigned BUS_W = PLANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              fb_rd,
    input  logic [BUS_W-1:0]  plane_data,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic [BUS_W-1:0]  latch_q
);

    logic [PLANES-1:0] ctl_color;
    logic [PLANES-1:0] ctl_mask;
    logic [SEL_W-1:0]  ctl_sel;
    logic              ctl_mode;
    logic [BYTE_W-1:0] cmp_byte;
    logic [BYTE_W-1:0] direct_byte;

    plane_ctl_regs #(
        .PLANES(PLANES),
        .BYTE_W(BYTE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .data_wr   (data_wr),
        .wdata     (wdata),
        .reg_rdata (reg_rdata),
        .color     (ctl_color),
        .mask      (ctl_mask),
        .sel       (ctl_sel),
        .cmp_mode  (ctl_mode)
    );

    plane_color_cmp #(
        .PLANES(PLANES),
        .BYTE_W(BYTE_W)
    ) u_cmp (
        .planes (plane_data),
        .color  (ctl_color),
        .mask   (ctl_mask),
        .match  (cmp_byte)
    );

    plane_sel_mux #(
        .PLANES(PLANES),
        .BYTE_W(BYTE_W)
    ) u_mux (
        .planes   (plane_data),
        .sel      (ctl_sel),
        .byte_out (direct_byte)
    );

    typedef struct packed {
        logic [BUS_W-1:0]  latch;
        logic [BYTE_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (fb_rd) begin
            rd_d.latch = plane_data;
            rd_d.rdata = ctl_mode ? cmp_byte : direct_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign cpu_rdata = rd_q.rdata;
    assign latch_q   = rd_q.latch;

endmodule

// File: rtl/plane_rd_unit_chk.sv
module plane_rd_unit_chk #(
    parameter int unsigned PLANES = 4,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1,
    localparam int unsigned BUS_W = PLANES * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fb_rd,
    input logic [BUS_W-1:0]  plane_data,
    input logic [BYTE_W-1:0] cpu_rdata,
    input logic [BUS_W-1:0]  latch_q,
    input logic              cmp_mode,
    input logic [PLANES-1:0] mask,
    input logic [SEL_W-1:0]  sel
);

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd |=> latch_q == $past(plane_data)); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_rd |=> $stable(latch_q)); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_rd |=> $stable(cpu_rdata)); // R10

    AST_DIRECT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rd && !cmp_mode) |=> cpu_rdata == $past(plane_data[sel*BYTE_W +: BYTE_W])); // R7

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rd && cmp_mode && mask == '0) |=> cpu_rdata == '1); // R9

endmodule

bind plane_rd_unit plane_rd_unit_chk #(
    .PLANES(PLANES),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fb_rd      (fb_rd),
    .plane_data (plane_data),
    .cpu_rdata  (cpu_rdata),
    .latch_q    (latch_q),
    .cmp_mode   (ctl_mode),
    .mask       (ctl_mask),
    .sel        (ctl_sel)
);

// File: tb/plane_rd_unit_test.sv
module plane_rd_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        idx_wr, data_wr, fb_rd;
    logic [7:0]  wdata, reg_rdata, cpu_rdata;
    logic [31:0] plane_data, latch_q;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_idx;
    logic [3:0] m_color, m_mask;
    logic [1:0] m_sel;
    logic       m_mode;
    logic [7:0] m_rdata;
    logic [31:0] m_latch;

    always #4 clk = ~clk;

    plane_rd_unit uut (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
        .wdata(wdata), .reg_rdata(reg_rdata), .fb_rd(fb_rd),
        .plane_data(plane_data), .cpu_rdata(cpu_rdata), .latch_q(latch_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(input logic [7:0] i);
        case (i)
            8'h02: return {4'h0, m_color};
            8'h04: return {6'h0, m_sel};
            8'h05: return {4'h0, m_mode, 3'h0};
            8'h07: return {4'h0, m_mask};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [31:0] p);
        logic [7:0] r;
        if (!m_mode) return p[m_sel*8 +: 8];
        for (int b = 0; b < 8; b++) begin
            r[b] = 1'b1;
            for (int q = 0; q < 4; q++)
                if (m_mask[q] && (p[q*8+b] != m_color[q])) r[b] = 1'b0;
        end
        return r;
    endfunction

    task automatic model_data(input logic [7:0] v);
        case (m_idx)
            8'h02: m_color = v[3:0];
            8'h04: m_sel   = v[1:0];
            8'h05: m_mode  = v[3];
            8'h07: m_mask  = v[3:0];
            default: ;
        endcase
    endtask

    task automatic bus_wr(input logic iw, input logic dw, input logic [7:0] v);
        @(negedge clk);
        idx_wr = iw; data_wr = dw; wdata = v;
        @(negedge clk);
        idx_wr = 0; data_wr = 0;
        if (dw) model_data(v);
        if (iw) m_idx = v;
    endtask

    task automatic wreg(input logic [7:0] i, input logic [7:0] v);
        bus_wr(1, 0, i);
        bus_wr(0, 1, v);
    endtask

    task automatic chk_reg(input string req, input logic [7:0] i);
        bus_wr(1, 0, i);
        check(req, {24'h0, reg_rdata}, {24'h0, exp_reg(i)});
    endtask

    task automatic do_read(input string req, input logic [31:0] p);
        @(negedge clk);
        fb_rd = 1; plane_data = p;
        @(negedge clk);
        fb_rd = 0;
        m_rdata = exp_read(p);
        m_latch = p;
        check(req, {24'h0, cpu_rdata}, {24'h0, m_rdata});
        check("R6", latch_q, m_latch);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; idx_wr = 0; data_wr = 0; fb_rd = 0; wdata = 0; plane_data = 0;
        m_idx = 0; m_color = 0; m_mask = 0; m_sel = 0; m_mode = 0;
        m_rdata = 0; m_latch = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1", {24'h0, cpu_rdata}, 32'h0);
        check("R1", latch_q, 32'h0);
        check("R1", {24'h0, reg_rdata}, 32'h0);
        chk_reg("R1", 8'h02);
        chk_reg("R1", 8'h05);
        chk_reg("R1", 8'h07);

        // R3 reserved mask bits
        wreg(8'h07, 8'hFF);
        check("R3", {24'h0, reg_rdata}, 32'h0000_000F);
        // R4 other registers
        wreg(8'h02, 8'hFA); check("R4", {24'h0, reg_rdata}, 32'h0000_000A);
        wreg(8'h04, 8'hFE); check("R4", {24'h0, reg_rdata}, 32'h0000_0002);
        wreg(8'h05, 8'hF7); check("R4", {24'h0, reg_rdata}, 32'h0000_0000);
        wreg(8'h05, 8'h08); check("R4", {24'h0, reg_rdata}, 32'h0000_0008);

        // R5 unassigned index
        wreg(8'h03, 8'hFF); check("R5", {24'h0, reg_rdata}, 32'h0);
        wreg(8'h06, 8'hFF); check("R5", {24'h0, reg_rdata}, 32'h0);
        chk_reg("R5", 8'h02);
        chk_reg("R5", 8'h04);
        chk_reg("R5", 8'h05);
        chk_reg("R5", 8'h07);

        // R2 index and data in the same cycle: data goes to old index 07h
        bus_wr(1, 1, 8'h02);
        check("R2", {24'h0, reg_rdata}, {24'h0, exp_reg(8'h02)});
        chk_reg("R2", 8'h07);
        check("R2", {24'h0, reg_rdata}, 32'h0000_0002);

        // R8 compare with all planes included
        wreg(8'h07, 8'h0F);
        wreg(8'h02, 8'h05);
        do_read("R8", {8'hF0, 8'h0F, 8'hF0, 8'h0F});
        check("R8", {24'h0, cpu_rdata}, 32'h0000_000F);
        do_read("R8", 32'hA5C3_3C5A);

        // R9 empty mask gives FFh, partial mask ignores excluded planes
        wreg(8'h07, 8'h00);
        do_read("R9", 32'h1234_5678);
        check("R9", {24'h0, cpu_rdata}, 32'h0000_00FF);
        wreg(8'h07, 8'h01);
        do_read("R9", {8'h55, 8'hAA, 8'h33, 8'h0F});
        check("R9", {24'h0, cpu_rdata}, 32'h0000_000F);

        // R10 output and latches hold without a strobe
        @(negedge clk);
        plane_data = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R10", {24'h0, cpu_rdata}, {24'h0, m_rdata});
        check("R6", latch_q, m_latch);

        // R7 and R11 direct mode with a mask and colour set
        wreg(8'h07, 8'h0F);
        wreg(8'h02, 8'h09);
        wreg(8'h05, 8'h00);
        for (int s = 0; s < 4; s++) begin
            wreg(8'h04, 8'(s));
            do_read("R7", 32'h44_33_22_11);
            check("R11", {24'h0, cpu_rdata}, {24'h0, 8'(8'h11 * (s + 1))});
        end

        // constrained random mix
        for (int it = 0; it < 600; it++) begin
            int unsigned k;
            k = $urandom_range(0, 9);
            if (k < 3) begin
                logic [7:0] idxs [5];
                idxs = '{8'h02, 8'h04, 8'h05, 8'h07, 8'h01};
                wreg(idxs[$urandom_range(0, 4)], 8'($urandom));
            end else if (k == 3) begin
                chk_reg("R4", 8'($urandom_range(0, 8)));
            end else if (k == 4) begin
                @(negedge clk);
                plane_data = $urandom;
                @(negedge clk);
                check("R10", {24'h0, cpu_rdata}, {24'h0, m_rdata});
            end else begin
                do_read(m_mode ? "R8" : "R7", $urandom);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule